// File: doc/BRIEF.md
# Image Scan Address Sequencer

This block feeds a pixel-wise binary operation of the form C(i,j) = A(i,j) op B(i,j) over three equal-sized images. The images lie row-major in one accelerator memory. A host gives the image width and height, one start address for each image and a traversal order, then pulses `start`. For every pixel position the block then emits three addresses. The first two are operand reads from images A and B, and the third is the result write into image C. All three use the same in-image offset `row*width + col` added to their own start address. Each address carries a tag that tells the memory port which access it is.

One Moore control machine steps through the states IDLE, RD_A, RD_B, WR_C, ADV, TURN and FIN. From IDLE, an accepted start goes to RD_A. The machine always runs RD_A, then RD_B, then WR_C. WR_C goes to FIN on the final pixel and to ADV otherwise. From ADV the machine goes to TURN, but only in the zig-zag order at a row end. In every other case ADV goes back to RD_A. TURN always goes to RD_A and FIN always goes to IDLE. A position tracker keeps the column, the row, a running linear offset and the column direction. It changes them only in ADV and TURN, so the offset never needs a multiplier.

Top module: `scan_addr_seq`

## Requirements
- R1: After reset, and whenever idle, `busy`, `addr_valid` and `done` are all 0.
- R2: Each visited pixel yields three consecutive emitting cycles: image A, then image B, then image C. The address in each is that image's start address plus `row*width + col`, taken modulo 2^ADDR_W.
- R3: The tag is 0 for the A read, 1 for the B read and 2 for the C write. The value 3 never appears with `addr_valid` high.
- R4: A pixel normally takes 4 cycles: the three emitting cycles followed by one cycle with `addr_valid` low.
- R5: Order code 0 (single step) visits only pixel (row 0, col 0).
- R6: Order code 1 (linear scan) visits row 0 only, columns 0 up to width-1.
- R7: Order code 2 (video scan) visits every row from 0 to height-1. Within each row it visits columns 0 up to width-1. At a line end the column returns to 0 and the row advances, with no extra cycle.
- R8: Order code 3 (zig-zag) runs even rows left to right and odd rows right to left. When it moves to the next row, that pixel step takes 5 cycles instead of 4.
- R9: `done` is high for exactly one cycle, the cycle after the write of the final pixel. The block is idle in the cycle after that.
- R10: `start` is taken only while idle. Width, height, order and the three start addresses are latched at that moment. A `start` pulse while busy, including the `done` cycle, changes nothing.
- R11: A `start` with width 0 or height 0 is ignored, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a traversal with the current settings |
| img_width | input | DIM_W | Pixels per row |
| img_height | input | DIM_W | Rows per image |
| order_sel | input | 2 | Traversal order: 0 single, 1 linear, 2 video, 3 zig-zag |
| base_a | input | ADDR_W | Start address of image A |
| base_b | input | ADDR_W | Start address of image B |
| base_c | input | ADDR_W | Start address of image C |
| addr_valid | output | 1 | An address is presented this cycle |
| addr | output | ADDR_W | Memory address |
| tag | output | 2 | Access kind: 0 read A, 1 read B, 2 write C |
| busy | output | 1 | A traversal is in progress |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
Every order is run on a 3x2 image, where single, linear and video produce streams of different lengths and end pixels. Zig-zag is also run with both odd and even heights, so the stream ends once at the right-hand end of a row and once at the left-hand end. This shows that the direction flip and the 5-cycle row change land in the correct cycles. Degenerate shapes (one column, one row, a single pixel) exercise the case where a pixel is both the first and the last of its row. A C start address near the top of the address space shows that addresses wrap. A run with extra start pulses in the middle and on the `done` cycle, and starts with a zero dimension, show that those starts are ignored.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_A,
        S_RD_B,
        S_WR_C,
        S_ADV,
        S_TURN,
        S_FIN
    } seq_state_t;

    typedef enum logic [2:0] {
        P_HOLD,
        P_LOAD,
        P_FWD,
        P_BACK,
        P_WRAP,
        P_TURN
    } pos_cmd_t;

    typedef enum logic [1:0] {
        ORD_SINGLE = 2'd0,
        ORD_LINEAR = 2'd1,
        ORD_VIDEO  = 2'd2,
        ORD_ZIGZAG = 2'd3
    } order_t;

    typedef enum logic [1:0] {
        TAG_RD_A = 2'd0,
        TAG_RD_B = 2'd1,
        TAG_WR_C = 2'd2,
        TAG_NONE = 2'd3
    } acc_tag_t;

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int DIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIM_W-1:0] width_in,
    input  logic [DIM_W-1:0] height_in,
    input  logic [1:0]       order_in,
    input  logic [DIM_W-1:0] col,
    input  logic [DIM_W-1:0] row,
    input  logic             rev,
    output pos_cmd_t         cmd,
    output logic [DIM_W-1:0] width_q,
    output logic             busy,
    output logic             done,
    output logic             addr_valid,
    output acc_tag_t         tag
);

    seq_state_t       state, state_nx;
    order_t           order_q;
    logic [DIM_W-1:0] height_q;
    logic             accept;
    logic             row_end;
    logic             last_pix;

    assign accept  = (state == S_IDLE) && start
                     && (width_in != '0) && (height_in != '0);
    assign row_end = rev ? (col == '0) : (col == width_q - DIM_W'(1));

    always_comb begin
        unique case (order_q)
            ORD_SINGLE: last_pix = 1'b1;
            ORD_LINEAR: last_pix = row_end;
            ORD_VIDEO:  last_pix = row_end && (row == height_q - DIM_W'(1));
            ORD_ZIGZAG: last_pix = row_end && (row == height_q - DIM_W'(1));
            default:    last_pix = 1'b1;
        endcase
    end

    // state register and latched settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            order_q  <= ORD_SINGLE;
            width_q  <= '0;
            height_q <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                order_q  <= order_t'(order_in);
                width_q  <= width_in;
                height_q <= height_in;
            end
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (accept) state_nx = S_RD_A;
            S_RD_A: state_nx = S_RD_B;
            S_RD_B: state_nx = S_WR_C;
            S_WR_C: state_nx = last_pix ? S_FIN : S_ADV;
            S_ADV:  state_nx = (order_q == ORD_ZIGZAG && row_end) ? S_TURN : S_RD_A;
            S_TURN: state_nx = S_RD_A;
            S_FIN:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs and position commands
    always_comb begin
        cmd        = P_HOLD;
        busy       = (state != S_IDLE);
        done       = 1'b0;
        addr_valid = 1'b0;
        tag        = TAG_NONE;
        unique case (state)
            S_IDLE: if (accept) cmd = P_LOAD;
            S_RD_A: begin addr_valid = 1'b1; tag = TAG_RD_A; end
            S_RD_B: begin addr_valid = 1'b1; tag = TAG_RD_B; end
            S_WR_C: begin addr_valid = 1'b1; tag = TAG_WR_C; end
            S_ADV: begin
                unique case (order_q)
                    ORD_ZIGZAG: cmd = row_end ? P_HOLD : (rev ? P_BACK : P_FWD);
                    ORD_VIDEO:  cmd = row_end ? P_WRAP : P_FWD;
                    ORD_LINEAR: cmd = P_FWD;
                    default:    cmd = P_HOLD;
                endcase
            end
            S_TURN: cmd = P_TURN;
            S_FIN:  done = 1'b1;
            default: cmd = P_HOLD;
        endcase
    end

endmodule

// File: rtl/scan_pos_track.sv
module scan_pos_track
    import scan_seq_pkg::*;
#(
    parameter int DIM_W = 8,
    localparam int OFS_W = 2 * DIM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pos_cmd_t         cmd,
    input  logic [DIM_W-1:0] width_q,
    output logic [DIM_W-1:0] col,
    output logic [DIM_W-1:0] row,
    output logic [OFS_W-1:0] ofs,
    output logic             rev
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col <= '0;
            row <= '0;
            ofs <= '0;
            rev <= 1'b0;
        end else begin
            unique case (cmd)
                P_LOAD: begin
                    col <= '0;
                    row <= '0;
                    ofs <= '0;
                    rev <= 1'b0;
                end
                P_FWD: begin
                    col <= col + DIM_W'(1);
                    ofs <= ofs + OFS_W'(1);
                end
                P_BACK: begin
                    col <= col - DIM_W'(1);
                    ofs <= ofs - OFS_W'(1);
                end
                P_WRAP: begin
                    col <= '0;
                    row <= row + DIM_W'(1);
                    ofs <= ofs + OFS_W'(1);
                end
                P_TURN: begin
                    row <= row + DIM_W'(1);
                    ofs <= ofs + OFS_W'(width_q);
                    rev <= ~rev;
                end
                default: begin end
            endcase
        end
    end

endmodule

// File: rtl/scan_addr_form.sv
module scan_addr_form
    import scan_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_a,
    input  logic [ADDR_W-1:0] base_b,
    input  logic [ADDR_W-1:0] base_c,
    input  acc_tag_t          tag,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] ba_q, bb_q, bc_q, sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ba_q <= '0;
            bb_q <= '0;
            bc_q <= '0;
        end else if (load) begin
            ba_q <= base_a;
            bb_q <= base_b;
            bc_q <= base_c;
        end
    end

    always_comb begin
        unique case (tag)
            TAG_RD_A: sel = ba_q;
            TAG_RD_B: sel = bb_q;
            TAG_WR_C: sel = bc_q;
            default:  sel = '0;
        endcase
    end

    assign addr = sel + ADDR_W'(ofs);

endmodule

// File: rtl/scan_addr_seq.sv
module scan_addr_seq
    import scan_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DIM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  img_width,
    input  logic [DIM_W-1:0]  img_height,
    input  logic [1:0]        order_sel,
    input  logic [ADDR_W-1:0] base_a,
    input  logic [ADDR_W-1:0] base_b,
    input  logic [ADDR_W-1:0] base_c,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        tag,
    output logic              busy,
    output logic              done
);

    localparam int OFS_W = 2 * DIM_W;

    pos_cmd_t         cmd;
    acc_tag_t         tag_e;
    logic [DIM_W-1:0] width_q, col, row;
    logic [OFS_W-1:0] ofs;
    logic             rev;

    scan_seq_ctrl #(.DIM_W(DIM_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .width_in(img_width), .height_in(img_height), .order_in(order_sel),
        .col(col), .row(row), .rev(rev),
        .cmd(cmd), .width_q(width_q), .busy(busy), .done(done),
        .addr_valid(addr_valid), .tag(tag_e)
    );

    scan_pos_track #(.DIM_W(DIM_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .width_q(width_q),
        .col(col), .row(row), .ofs(ofs), .rev(rev)
    );

    scan_addr_form #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(cmd == P_LOAD),
        .base_a(base_a), .base_b(base_b), .base_c(base_c),
        .tag(tag_e), .ofs(ofs), .addr(addr)
    );

    assign tag = tag_e;

endmodule

// File: rtl/scan_addr_seq_chk.sv
module scan_addr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       addr_valid,
    input logic [1:0] tag,
    input logic       busy,
    input logic       done
);

    assert_tag_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (tag != 2'd3));

    assert_a_then_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && tag == 2'd0) |=> (addr_valid && tag == 2'd1));

    assert_b_then_c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && tag == 2'd1) |=> (addr_valid && tag == 2'd2));

    assert_quiet_after_c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && tag == 2'd2) |=> !addr_valid);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!addr_valid && !done));

endmodule

bind scan_addr_seq scan_addr_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid),
    .tag(tag), .busy(busy), .done(done)
);

// File: tb/scan_addr_seq_test.sv
module scan_addr_seq_test;

    localparam int ADDR_W = 16;
    localparam int DIM_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [DIM_W-1:0]  img_width = '0, img_height = '0;
    logic [1:0]        order_sel = '0;
    logic [ADDR_W-1:0] base_a = '0, base_b = '0, base_c = '0;
    logic              addr_valid, busy, done;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        tag;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        bit              v;
        bit [1:0]        t;
        bit [ADDR_W-1:0] a;
        bit              d;
    } ent_t;

    ent_t exp_q[$];

    always #5 clk = ~clk;

    scan_addr_seq #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .img_width(img_width), .img_height(img_height), .order_sel(order_sel),
        .base_a(base_a), .base_b(base_b), .base_c(base_c),
        .addr_valid(addr_valid), .addr(addr), .tag(tag),
        .busy(busy), .done(done)
    );

    task automatic push(bit v, bit [1:0] t, int a, bit d);
        ent_t e;
        e.v = v; e.t = t; e.a = ADDR_W'(a); e.d = d;
        exp_q.push_back(e);
    endtask

    // reference: list pixels in order, then expand into per-cycle entries
    task automatic build(int pat, int n, int m, int ba, int bb, int bc);
        int pr[$];
        int pc[$];
        exp_q.delete();
        if (pat == 0) begin
            pr.push_back(0); pc.push_back(0);
        end else if (pat == 1) begin
            for (int c = 0; c < n; c++) begin pr.push_back(0); pc.push_back(c); end
        end else begin
            for (int r = 0; r < m; r++)
                for (int k = 0; k < n; k++) begin
                    pr.push_back(r);
                    pc.push_back((pat == 3 && (r % 2) == 1) ? n - 1 - k : k);
                end
        end
        for (int i = 0; i < pr.size(); i++) begin
            int o;
            o = pr[i] * n + pc[i];
            push(1, 2'd0, ba + o, 0);
            push(1, 2'd1, bb + o, 0);
            push(1, 2'd2, bc + o, 0);
            if (i == pr.size() - 1) push(0, 2'd0, 0, 1);
            else begin
                push(0, 2'd0, 0, 0);
                if (pat == 3 && pr[i+1] != pr[i]) push(0, 2'd0, 0, 0);
            end
        end
    endtask

    task automatic check_ent(ent_t e, string req, int idx);
        bit ok;
        n_cmp++;
        ok = (addr_valid == e.v) && (done == e.d) && (busy == 1'b1)
             && (!e.v || (tag == e.t && addr == e.a));
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cyc %0d: got v=%0b t=%0d a=%h d=%0b busy=%0b exp v=%0b t=%0d a=%h d=%0b busy=1",
                     req, idx, addr_valid, tag, addr, done, busy, e.v, e.t, e.a, e.d);
        end
    endtask

    task automatic check_idle(string req);
        n_cmp++;
        if (busy || addr_valid || done) begin
            n_bad++;
            $display("FAIL %s idle: got busy=%0b v=%0b d=%0b exp 0 0 0", req, busy, addr_valid, done);
        end
    endtask

    // intrude: cycle index at which a stray start with other settings is driven (-1 none)
    task automatic run(int pat, int n, int m, int ba, int bb, int bc, string req, int intrude);
        build(pat, n, m, ba, bb, bc);
        @(negedge clk);
        order_sel = 2'(pat); img_width = DIM_W'(n); img_height = DIM_W'(m);
        base_a = ADDR_W'(ba); base_b = ADDR_W'(bb); base_c = ADDR_W'(bc);
        start = 1'b1;
        for (int i = 0; i < exp_q.size(); i++) begin
            @(negedge clk);
            start = 1'b0;
            check_ent(exp_q[i], req, i);
            if (i == intrude || (intrude >= 0 && i == exp_q.size() - 1)) begin
                // R10: stray start while busy with different settings
                start = 1'b1; order_sel = 2'd2; img_width = 8'd5; img_height = 8'd5;
                base_a = 16'h7777; base_b = 16'h6666; base_c = 16'h5555;
            end
        end
        @(negedge clk);
        start = 1'b0;
        check_idle({req, "/R9"});
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        run(0, 3, 2, 16'h0100, 16'h0200, 16'h0300, "R5", -1);
        run(1, 3, 2, 16'h0100, 16'h0200, 16'h0300, "R6", -1);
        run(2, 3, 2, 16'h0100, 16'h0200, 16'h0300, "R7", -1);
        run(3, 3, 2, 16'h0100, 16'h0200, 16'h0300, "R8", -1);
        run(3, 4, 3, 16'h1000, 16'h2000, 16'h3000, "R8", -1);
        run(2, 4, 3, 16'h1000, 16'h2000, 16'hFFFE, "R2", -1);
        run(3, 1, 3, 16'h0040, 16'h0080, 16'h00C0, "R8", -1);
        run(2, 1, 3, 16'h0040, 16'h0080, 16'h00C0, "R7", -1);
        run(3, 3, 1, 16'h0040, 16'h0080, 16'h00C0, "R8", -1);
        run(1, 1, 1, 16'h0040, 16'h0080, 16'h00C0, "R6", -1);
        run(3, 1, 1, 16'h0040, 16'h0080, 16'h00C0, "R4", -1);
        run(3, 3, 3, 16'h0500, 16'h0600, 16'h0700, "R10", 5);

        // R11: zero width, then zero height
        @(negedge clk);
        img_width = 8'd0; img_height = 8'd3; order_sel = 2'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_idle("R11");
        img_width = 8'd3; img_height = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_idle("R11");

        // R10: settings changed while idle do not disturb a later run
        run(2, 2, 2, 16'h0010, 16'h0020, 16'h0030, "R10", -1);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule